// File: doc/BRIEF.md
# Integer to Unpacked Float Converter

This block turns a 32-bit or 64-bit integer into an unpacked floating-point record. The record is meant for an arithmetic core that works on a wide, unrounded form. The record carries a sign, a signed exponent, a 128-bit mantissa made of four 32-bit words, a sticky bit and a class code. Word 0 of the mantissa is bits 127:96, word 1 is bits 95:64, word 2 is bits 63:32 and word 3 is bits 31:0. A caller presents the integer together with three selects: width, signedness and a sign flag. It uses a valid/ready handshake, then collects the record through a second valid/ready pair.

The block first works out the integer's magnitude and loads it at a fixed nominal exponent. In narrow mode the magnitude goes into word 0 and the exponent is 19. In wide mode its upper half goes into word 0, its lower half into word 1, and the exponent is 51. The block then shifts the mantissa until its leading one sits at bit 19 of word 0, which is absolute bit 115, and adjusts the exponent by the same amount. A value whose leading one starts above that bit is shifted right in a single step. A value whose leading one starts below it is shifted left by at most `NORM_STEP` positions per cycle. Each step is sized by a leading-zero count.

The controller has three states. `ST_IDLE` waits for input. `ST_NORM` runs the shift steps. `ST_HOLD` presents the record. The transitions are:
- `ST_IDLE` to `ST_NORM` when a nonzero value is accepted.
- `ST_IDLE` to `ST_HOLD` when a zero value is accepted.
- `ST_NORM` to `ST_HOLD` once the leading one is in place.
- `ST_HOLD` to `ST_IDLE` when the consumer takes the record.

Top module: `int_to_unpacked_float`

## Requirements
- R1: `in_ready` is high only in the idle state. A value is taken on a clock edge where `in_valid` and `in_ready` are both high, after which `in_ready` drops until the record is consumed. `out_valid` stays high until a clock edge with `out_ready` high.
- R2: With `in_wide` = 0, only `in_value[31:0]` is used. Bits 63:32 have no effect on the record, including the zero test and the negation test.
- R3: A zero magnitude gives class 0 (ZERO). The mantissa and exponent outputs keep the values of the previous record.
- R4: A nonzero magnitude gives class 1 (NUM). The other codes are INF = 2, QNAN = 3 and SNAN = 4; this block never produces them.
- R5: With `in_signed` = 1, `in_neg` = 1 and the top bit of the selected width set (bit 31 narrow, bit 63 wide), the magnitude is the two's complement negation within that width. The most negative value therefore yields 2^31 or 2^63, read as unsigned.
- R6: With `in_signed` = 0, or with `in_neg` = 0, the selected bits are used unchanged as the magnitude.
- R7: For class NUM, `out_mant` equals the magnitude shifted left by (115 − q), where q is the bit index of the magnitude's leading one. Bit 115 is therefore set and bits 127:116 are clear.
- R8: For class NUM, `out_exp` equals q, in the range 0 to 63.
- R9: `out_sticky` is 0 in every record, because the 128-bit mantissa holds every shifted bit.
- R10: `out_sign` equals `in_neg` as captured with the value.
- R11: While `out_valid` is high and `out_ready` is low, every record output is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can accept a value |
| in_value | input | 64 | Integer bits; only 31:0 used when narrow |
| in_wide | input | 1 | 1 = 64-bit input, 0 = 32-bit input |
| in_signed | input | 1 | 1 = treat value as two's complement |
| in_neg | input | 1 | Sign flag; enables negation and becomes the record sign |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_sign | output | 1 | Record sign |
| out_exp | output | 12 | Signed record exponent |
| out_mant | output | 128 | Mantissa, word 0 in bits 127:96 |
| out_sticky | output | 1 | OR of bits shifted out of the mantissa |
| out_class | output | 3 | Class code (0 ZERO, 1 NUM) |

## Verification
The bench builds the block with `NORM_STEP` = 8 and every other parameter at its default. With that step, the widest left normalization (a wide input of 1, moved 51 places) runs through seven `ST_NORM` updates before the record appears. Supernormal narrow inputs such as all-ones take the single right-shift path instead. The directed cases cover:
- the most negative values in both widths;
- negative bit patterns with the flag clear or with unsigned mode selected;
- upper-half garbage in narrow mode, including a value that only looks nonzero in its ignored half;
- a consumer that stalls while a record is held.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } num_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_HOLD = 2'd2
    } conv_state_e;

endpackage

// File: rtl/i2f_lzc.sv
// Leading-zero counter over a W-bit vector; an all-zero vector gives W.
module i2f_lzc #(
    parameter int W  = 128,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/i2f_loader.sv
// Builds the magnitude from the selected width and places it at the nominal exponent.
module i2f_loader #(
    parameter int IN_W   = 64,
    parameter int WORD_W = 32,
    parameter int MANT_W = 128,
    parameter int EXP_W  = 12,
    parameter int LG     = 19
) (
    input  logic                    [IN_W-1:0]   value,
    input  logic                                 wide,
    input  logic                                 is_signed,
    input  logic                                 neg_flag,
    output logic                    [MANT_W-1:0] mant_init,
    output logic signed             [EXP_W-1:0]  exp_init,
    output logic                                 is_zero
);
    localparam int HALF_W = IN_W / 2;

    logic [HALF_W-1:0] narrow;
    logic [HALF_W-1:0] narrow_mag;
    logic [IN_W-1:0]   wide_mag;
    logic              narrow_top;
    logic              wide_top;

    assign narrow     = value[HALF_W-1:0];
    assign narrow_top = narrow[HALF_W-1];
    assign wide_top   = value[IN_W-1];

    // Negation happens only when signed mode, the flag and the top bit all agree.
    always_comb begin
        narrow_mag = narrow;
        if (is_signed && neg_flag && narrow_top) begin
            narrow_mag = ~narrow + 1'b1;
        end
        wide_mag = value;
        if (is_signed && neg_flag && wide_top) begin
            wide_mag = ~value + 1'b1;
        end
    end

    always_comb begin
        if (wide) begin
            mant_init = {wide_mag, {(MANT_W - IN_W){1'b0}}};
            exp_init  = EXP_W'(LG + WORD_W);
            is_zero   = (wide_mag == '0);
        end else begin
            mant_init = {narrow_mag, {(MANT_W - HALF_W){1'b0}}};
            exp_init  = EXP_W'(LG);
            is_zero   = (narrow_mag == '0);
        end
    end
endmodule

// File: rtl/i2f_norm_step.sv
// One normalization step: a full right shift for supernormals, or a bounded left shift.
module i2f_norm_step #(
    parameter int MANT_W  = 128,
    parameter int EXP_W   = 12,
    parameter int TOP_POS = 115,
    parameter int STEP    = 16
) (
    input  logic        [MANT_W-1:0] mant,
    input  logic signed [EXP_W-1:0]  exp_in,
    output logic        [MANT_W-1:0] mant_nx,
    output logic signed [EXP_W-1:0]  exp_nx,
    output logic                     sticky_nx,
    output logic                     aligned
);
    localparam int CW = $clog2(MANT_W + 1);
    localparam logic [CW-1:0] TGT    = CW'(MANT_W - 1 - TOP_POS);
    localparam logic [CW-1:0] STEP_C = CW'(STEP);
    localparam logic [CW-1:0] EMPTY  = CW'(MANT_W);

    logic [CW-1:0] lz;
    logic [CW-1:0] rsh;
    logic [CW-1:0] lsh;

    i2f_lzc #(.W(MANT_W), .CW(CW)) u_lzc (
        .vec   (mant),
        .count (lz)
    );

    always_comb begin
        mant_nx   = mant;
        exp_nx    = exp_in;
        sticky_nx = 1'b0;
        aligned   = (lz == TGT);
        rsh       = '0;
        lsh       = '0;
        if (lz < TGT) begin
            rsh = TGT - lz;
            for (int i = 0; i < MANT_W; i++) begin
                if (i < int'(rsh)) begin
                    sticky_nx = sticky_nx | mant[i];
                end
            end
            mant_nx = mant >> rsh;
            exp_nx  = exp_in + EXP_W'(rsh);
        end else if (lz > TGT && lz != EMPTY) begin
            lsh     = ((lz - TGT) > STEP_C) ? STEP_C : (lz - TGT);
            mant_nx = mant << lsh;
            exp_nx  = exp_in - EXP_W'(lsh);
        end
    end
endmodule

// File: rtl/int_to_unpacked_float.sv
module int_to_unpacked_float
    import i2f_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int IN_W      = 64,
    parameter int WORDS     = 4,
    parameter int EXP_W     = 12,
    parameter int LG        = 19,
    parameter int NORM_STEP = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic        [IN_W-1:0]         in_value,
    input  logic                           in_wide,
    input  logic                           in_signed,
    input  logic                           in_neg,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic                           out_sign,
    output logic signed [EXP_W-1:0]        out_exp,
    output logic        [WORDS*WORD_W-1:0] out_mant,
    output logic                           out_sticky,
    output logic        [2:0]              out_class
);
    localparam int MANT_W  = WORDS * WORD_W;
    localparam int TOP_POS = MANT_W - WORD_W + LG;

    conv_state_e state, state_nx;

    logic        [MANT_W-1:0] mant_q;
    logic signed [EXP_W-1:0]  exp_q;
    logic                     sign_q;
    logic                     sticky_q;
    num_class_e               cls_q;

    logic        [MANT_W-1:0] ld_mant;
    logic signed [EXP_W-1:0]  ld_exp;
    logic                     ld_zero;

    logic        [MANT_W-1:0] nx_mant;
    logic signed [EXP_W-1:0]  nx_exp;
    logic                     nx_sticky;
    logic                     aligned;

    i2f_loader #(
        .IN_W   (IN_W),
        .WORD_W (WORD_W),
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .LG     (LG)
    ) u_loader (
        .value     (in_value),
        .wide      (in_wide),
        .is_signed (in_signed),
        .neg_flag  (in_neg),
        .mant_init (ld_mant),
        .exp_init  (ld_exp),
        .is_zero   (ld_zero)
    );

    i2f_norm_step #(
        .MANT_W  (MANT_W),
        .EXP_W   (EXP_W),
        .TOP_POS (TOP_POS),
        .STEP    (NORM_STEP)
    ) u_norm (
        .mant      (mant_q),
        .exp_in    (exp_q),
        .mant_nx   (nx_mant),
        .exp_nx    (nx_exp),
        .sticky_nx (nx_sticky),
        .aligned   (aligned)
    );

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ld_zero ? ST_HOLD : ST_NORM;
            ST_NORM: if (aligned)   state_nx = ST_HOLD;
            ST_HOLD: if (out_ready) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Record registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_q   <= '0;
            exp_q    <= '0;
            sign_q   <= 1'b0;
            sticky_q <= 1'b0;
            cls_q    <= CLS_ZERO;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        sign_q   <= in_neg;
                        sticky_q <= 1'b0;
                        if (ld_zero) begin
                            cls_q <= CLS_ZERO;
                        end else begin
                            cls_q  <= CLS_NUM;
                            mant_q <= ld_mant;
                            exp_q  <= ld_exp;
                        end
                    end
                end
                ST_NORM: begin
                    if (!aligned) begin
                        mant_q   <= nx_mant;
                        exp_q    <= nx_exp;
                        sticky_q <= sticky_q | nx_sticky;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign in_ready   = (state == ST_IDLE);
    assign out_valid  = (state == ST_HOLD);
    assign out_sign   = sign_q;
    assign out_exp    = exp_q;
    assign out_mant   = mant_q;
    assign out_sticky = sticky_q;
    assign out_class  = cls_q;

    // R1: an accepted value closes the input side on the next cycle
    p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R11: a stalled record does not move
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mant) && $stable(out_exp)
                                       && $stable(out_class) && $stable(out_sign)));

    // R7: a NUM record has its leading one at the target bit
    p_num_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_NUM) |->
            (out_mant[TOP_POS] && ((out_mant >> (TOP_POS + 1)) == '0)));

    // R3: a zero input yields ZERO at once and leaves mantissa and exponent alone
    p_zero_retains_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ld_zero) |=>
            (out_valid && out_class == CLS_ZERO && $stable(out_mant) && $stable(out_exp)));

    // R9: no bit is ever lost off the low end
    p_sticky_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_sticky);

    // R10: the record sign follows the flag captured with the value
    p_sign_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_sign == $past(in_neg)));

    // R8: a NUM exponent lies in the input's bit-index range
    p_exp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_NUM) |->
            (!out_exp[EXP_W-1] && (out_exp < EXP_W'(IN_W))));
endmodule

// File: tb/int_to_unpacked_float_bench.sv
module int_to_unpacked_float_bench;
    localparam int STEP    = 8;
    localparam int TOP_POS = 115;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_value = '0;
    logic         in_wide = 1'b0;
    logic         in_signed = 1'b0;
    logic         in_neg = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         out_sign;
    logic [11:0]  out_exp;
    logic [127:0] out_mant;
    logic         out_sticky;
    logic [2:0]   out_class;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [127:0] last_mant = '0;
    logic [11:0]  last_exp  = '0;

    always #10 clk = ~clk;

    int_to_unpacked_float #(.NORM_STEP(STEP)) u_int_to_unpacked_float (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_value(in_value),
        .in_wide(in_wide), .in_signed(in_signed), .in_neg(in_neg),
        .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_sticky(out_sticky),
        .out_class(out_class)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 watchdog: actual %0d cycles expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [63:0] v, logic w, logic s, logic n);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_value = v; in_wide = w; in_signed = s; in_neg = n; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_value = 64'hA5A5_A5A5_A5A5_A5A5;
    endtask

    task automatic wait_valid(string req);
        int t = 0;
        while (!out_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(req, "out_valid", 128'(out_valid), 128'd1);
    endtask

    task automatic consume();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Sends a value and checks the NUM record against the expected magnitude.
    task automatic run_num(string req, logic [63:0] v, logic w, logic s, logic n, logic [63:0] mag);
        int q = 0;
        logic [127:0] em;
        for (int i = 0; i < 64; i++) if (mag[i]) q = i;
        em = {64'b0, mag} << (TOP_POS - q);
        send(v, w, s, n);
        wait_valid(req);
        check(req, "class (R4)", 128'(out_class), 128'd1);
        check(req, "mantissa (R7)", out_mant, em);
        check(req, "exponent (R8)", 128'(out_exp), 128'(12'(q)));
        check(req, "sign (R10)", 128'(out_sign), 128'(n));
        check(req, "sticky (R9)", 128'(out_sticky), 128'd0);
        last_mant = em;
        last_exp  = 12'(q);
        consume();
    endtask

    task automatic run_zero(string req, logic [63:0] v, logic w, logic s, logic n);
        send(v, w, s, n);
        wait_valid(req);
        check(req, "class ZERO (R3)", 128'(out_class), 128'd0);
        check(req, "mantissa kept (R3)", out_mant, last_mant);
        check(req, "exponent kept (R3)", 128'(out_exp), 128'(last_exp));
        check(req, "sign (R10)", 128'(out_sign), 128'(n));
        consume();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "reset in_ready", 128'(in_ready), 128'd1);
        check("R1", "reset out_valid", 128'(out_valid), 128'd0);
        check("R3", "reset class", 128'(out_class), 128'd0);
        check("R7", "reset mantissa", out_mant, 128'd0);
    endtask

    task automatic t_narrow_unsigned();
        run_num("R7", 64'h1, 1'b0, 1'b0, 1'b0, 64'h1);
        run_num("R7", 64'h8_0000, 1'b0, 1'b0, 1'b0, 64'h8_0000);
        run_num("R8", 64'h1_2345, 1'b0, 1'b0, 1'b0, 64'h1_2345);
        run_num("R8", 64'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF);
    endtask

    task automatic t_wide_unsigned();
        run_num("R7", 64'h1, 1'b1, 1'b0, 1'b0, 64'h1);
        run_num("R8", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        run_num("R7", 64'h1_0000_0000, 1'b1, 1'b0, 1'b0, 64'h1_0000_0000);
        run_num("R8", 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_signed_negate();
        run_num("R5", 64'hFFFF_FFFB, 1'b0, 1'b1, 1'b1, 64'h5);
        run_num("R5", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 64'h1);
        run_num("R5", 64'h8000_0000, 1'b0, 1'b1, 1'b1, 64'h8000_0000);
        run_num("R5", 64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_no_negate();
        run_num("R6", 64'hFFFF_FFFB, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFB);
        run_num("R6", 64'hFFFF_FFFB, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFB);
        run_num("R6", 64'hF000_0000_0000_0010, 1'b1, 1'b0, 1'b1, 64'hF000_0000_0000_0010);
    endtask

    task automatic t_narrow_upper_ignored();
        run_num("R2", 64'hDEAD_BEEF_0000_0040, 1'b0, 1'b0, 1'b0, 64'h40);
        run_num("R2", 64'hFFFF_FFFF_0000_0003, 1'b0, 1'b1, 1'b1, 64'h3);
        run_zero("R2", 64'h0000_0001_0000_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero();
        run_num("R3", 64'h2A, 1'b0, 1'b0, 1'b0, 64'h2A);
        run_zero("R3", 64'h0, 1'b0, 1'b1, 1'b1);
        run_zero("R3", 64'h0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_backpressure();
        logic [127:0] held;
        send(64'h0000_0003_0000_0000, 1'b1, 1'b0, 1'b0);
        wait_valid("R11");
        held = out_mant;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R11", "stalled out_valid", 128'(out_valid), 128'd1);
            check("R11", "stalled mantissa", out_mant, held);
            check("R1", "in_ready while held", 128'(in_ready), 128'd0);
        end
        check("R7", "stalled record value", held, {64'b0, 64'h3_0000_0000} << (TOP_POS - 33));
        consume();
        check("R1", "in_ready after consume", 128'(in_ready), 128'd1);
        last_mant = held;
        last_exp  = 12'd33;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_narrow_unsigned();
        t_wide_unsigned();
        t_signed_negate();
        t_no_negate();
        t_narrow_upper_ignored();
        t_zero();
        t_backpressure();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule